// File: doc/BRIEF.md
# 4x4 Block Texel Decoder

This block expands one 64-bit compressed texture block into 32-bit RGBA texels covering a 4x4 square. The block holds two 16-bit endpoint colours and a 32-bit word of 2-bit selectors, one selector per texel. From the two endpoints the decoder builds a four-entry colour table. Comparing the endpoints as unsigned numbers picks one of two table layouts. In one layout both middle entries are interpolated. In the other, one entry is the average of the endpoints and the last entry is fully transparent black.

A client can ask for one texel by index, and the answer appears on the output one cycle later. A client can also ask for the whole block. The 16 texels then leave on consecutive cycles in raster order, and further requests are ignored while the sequence runs. The storage cost is fixed at 4 bits per texel, which is a 6:1 reduction against 24-bit RGB whatever the content.

Top module: `texblk_decoder`

## Requirements
- R1: Endpoint C0 is block bits [15:0] and endpoint C1 is bits [31:16]. Each endpoint is RGB565 with red in [15:11], green in [10:5] and blue in [4:0]. Table entries 0 and 1 are C0 and C1.
- R2: Each narrow channel is widened to 8 bits by appending its own top bits (5-bit v gives {v, v[4:2]}, 6-bit v gives {v, v[5:4]}).
- R3: When C0 > C1 (unsigned), entry 2 is floor((2*C0 + C1)/3) and entry 3 is floor((C0 + 2*C1)/3), computed per 8-bit channel.
- R4: When C0 <= C1, entry 2 is floor((C0 + C1)/2) per channel and entry 3 is 32'h00000000. Equal endpoints select this layout.
- R5: out_rgba is packed {R[31:24], G[23:16], B[15:8], A[7:0]}. Every entry except transparent black has A = 8'hFF.
- R6: The selector of texel i (i = 4*row + column, 0 at top left) is block bits [33+2i:32+2i], and it picks the table entry with that number.
- R7: A single request (req_valid=1, req_whole=0) accepted while busy=0 gives out_valid=1 one cycle later, with out_index equal to req_index and the selected texel on out_rgba.
- R8: A whole-block request (req_valid=1, req_whole=1) accepted while busy=0 gives out_valid=1 on the next 16 cycles, with out_index running 0 to 15 and each texel taken from the captured block.
- R9: busy is 1 while the block sequence still has texels to emit after the current one. It is 0 while texel 15 is on the output. Requests presented while busy=1 have no effect on the outputs.
- R10: While rst_n is low, and in any cycle after an edge where no request was accepted and no sequence ran, out_valid and busy are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken at a rising edge when busy is 0 |
| req_whole | input | 1 | 1 = stream all 16 texels, 0 = one texel |
| req_index | input | 4 | Texel index for a single request |
| req_block | input | 64 | Compressed block |
| out_valid | output | 1 | out_index and out_rgba hold a texel |
| out_index | output | 4 | Index of the texel on out_rgba |
| out_rgba | output | 32 | Decoded texel, R G B A from the top byte down |
| busy | output | 1 | Block sequence running, requests ignored |

## Verification
A single-texel result is due one cycle after the accepting edge. Texel k of a whole-block request is due k+1 cycles after its accepting edge. The bench drives every request on a falling edge and samples on the following falling edges, one sample per due cycle, so each value is read halfway between the edge that produced it and the next one. During a sequence the bench presents competing requests and checks that index, colour and busy follow the original block without a gap. It also checks that a request made while texel 15 is showing is taken on the very next edge.

// File: rtl/texblk_pkg.sv
package texblk_pkg;

    localparam int CH_W      = 8;
    localparam int EP_W      = 16;
    localparam int SEL_W     = 2;
    localparam int PAL_N     = 1 << SEL_W;
    localparam int IDX_W     = 4;
    localparam int TEXELS    = 1 << IDX_W;
    localparam int SEL_LSB   = 2 * EP_W;
    localparam int BLOCK_W   = SEL_LSB + SEL_W * TEXELS;
    localparam int RGBA_W    = 4 * CH_W;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
        logic [CH_W-1:0] a;
    } rgba8_t;

    localparam rgba8_t CLEAR_BLACK = '{r: '0, g: '0, b: '0, a: '0};

endpackage

// File: rtl/texblk_widen.sv
module texblk_widen #(
    parameter int IN_W  = 5,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  narrow,
    output logic [OUT_W-1:0] wide
);
    localparam int PAD_W = OUT_W - IN_W;

    // R2: fill the low bits with copies of the top bits
    assign wide = {narrow, narrow[IN_W-1 -: PAD_W]};

endmodule

// File: rtl/texblk_palette.sv
module texblk_palette
    import texblk_pkg::*;
(
    input  logic [EP_W-1:0] ep0,
    input  logic [EP_W-1:0] ep1,
    output rgba8_t          pal [PAL_N],
    output logic            four_mode
);
    localparam int NCH = 3;
    localparam int FLD_LSB [NCH] = '{11, 5, 0};
    localparam int FLD_W   [NCH] = '{5, 6, 5};

    logic [CH_W-1:0] w0  [NCH];
    logic [CH_W-1:0] w1  [NCH];
    logic [CH_W-1:0] t2  [NCH];
    logic [CH_W-1:0] t3  [NCH];
    logic [CH_W-1:0] avg [NCH];

    // R3: unsigned compare of the raw endpoints picks the layout
    assign four_mode = ep0 > ep1;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [CH_W+1:0] a_x;
        logic [CH_W+1:0] b_x;

        texblk_widen #(.IN_W(FLD_W[ch]), .OUT_W(CH_W)) u_w0 (
            .narrow (ep0[FLD_LSB[ch] +: FLD_W[ch]]),
            .wide   (w0[ch])
        );
        texblk_widen #(.IN_W(FLD_W[ch]), .OUT_W(CH_W)) u_w1 (
            .narrow (ep1[FLD_LSB[ch] +: FLD_W[ch]]),
            .wide   (w1[ch])
        );

        assign a_x     = {2'b00, w0[ch]};
        assign b_x     = {2'b00, w1[ch]};
        assign t2[ch]  = CH_W'(((a_x << 1) + b_x) / (CH_W+2)'(3));
        assign t3[ch]  = CH_W'((a_x + (b_x << 1)) / (CH_W+2)'(3));
        assign avg[ch] = CH_W'((a_x + b_x) >> 1);
    end

    always_comb begin
        pal[0] = '{r: w0[0], g: w0[1], b: w0[2], a: '1};
        pal[1] = '{r: w1[0], g: w1[1], b: w1[2], a: '1};
        if (four_mode) begin
            pal[2] = '{r: t2[0], g: t2[1], b: t2[2], a: '1};
            pal[3] = '{r: t3[0], g: t3[1], b: t3[2], a: '1};
        end else begin
            // R4: midpoint plus transparent black
            pal[2] = '{r: avg[0], g: avg[1], b: avg[2], a: '1};
            pal[3] = CLEAR_BLACK;
        end
    end

endmodule

// File: rtl/texblk_pick.sv
module texblk_pick
    import texblk_pkg::*;
(
    input  logic [BLOCK_W-1:0] block,
    input  logic [IDX_W-1:0]   idx,
    output rgba8_t             texel
);
    rgba8_t           pal [PAL_N];
    logic             four_mode;
    logic [SEL_W-1:0] sel;

    texblk_palette u_pal (
        .ep0       (block[EP_W-1:0]),
        .ep1       (block[2*EP_W-1:EP_W]),
        .pal       (pal),
        .four_mode (four_mode)
    );

    // R6: selector i occupies two bits starting at SEL_LSB + 2*i
    assign sel   = block[SEL_LSB + SEL_W * idx +: SEL_W];
    assign texel = pal[sel];

    always_comb begin
        if (!four_mode && sel == SEL_W'(PAL_N - 1)) begin
            assert (texel == CLEAR_BLACK)
                else $error("assert_clear_entry_R4");
        end
    end

endmodule

// File: rtl/texblk_decoder.sv
module texblk_decoder
    import texblk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_whole,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [BLOCK_W-1:0] req_block,
    output logic               out_valid,
    output logic [IDX_W-1:0]   out_index,
    output logic [RGBA_W-1:0]  out_rgba,
    output logic               busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TEXELS - 1);

    typedef struct packed {
        logic               active;
        logic [IDX_W-1:0]   cnt;
        logic [BLOCK_W-1:0] blk;
        logic               ov;
        logic [IDX_W-1:0]   oidx;
        rgba8_t             pix;
    } seq_t;

    seq_t               st_q, st_d;
    logic [BLOCK_W-1:0] pick_blk;
    logic [IDX_W-1:0]   pick_idx;
    rgba8_t             pick_pix;

    // one decode path, fed by the captured block or the request
    always_comb begin
        if (st_q.active) begin
            pick_blk = st_q.blk;
            pick_idx = st_q.cnt;
        end else begin
            pick_blk = req_block;
            pick_idx = req_whole ? '0 : req_index;
        end
    end

    texblk_pick u_pick (
        .block (pick_blk),
        .idx   (pick_idx),
        .texel (pick_pix)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (st_q.active) begin
            // R8/R9: sequence owns the datapath, requests dropped
            st_d.ov   = 1'b1;
            st_d.oidx = st_q.cnt;
            st_d.pix  = pick_pix;
            if (st_q.cnt == LAST_IDX) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (req_valid) begin
            st_d.ov   = 1'b1;
            st_d.oidx = pick_idx;
            st_d.pix  = pick_pix;
            if (req_whole) begin
                st_d.active = 1'b1;
                st_d.blk    = req_block;
                st_d.cnt    = IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_index = st_q.oidx;
    assign out_rgba  = st_q.pix;
    assign busy      = st_q.active;

    assert_single_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_whole) |=> (out_valid && !busy && out_index == $past(req_index)));

    assert_stream_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_whole) |=> (out_valid && busy && out_index == '0));

    assert_stream_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (out_valid && out_index == $past(out_index) + 1'b1));

    assert_busy_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_index == LAST_IDX && busy) |-> 1'b0 || !busy);

    assert_alpha_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rgba[CH_W-1:0] == '1 || out_rgba == '0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> (!out_valid && !busy));

endmodule

// File: tb/tb_texblk_decoder.sv
module tb_texblk_decoder;
    import texblk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 18;

    // {block, index, expected RGBA}
    localparam logic [BLOCK_W+IDX_W+RGBA_W-1:0] VECS [NVEC] = '{
        // four-colour layout, red/blue endpoints, selectors 0,1,2,3 repeating (R1 R3 R6)
        {64'hE4E4E4E4_001F_F800, 4'd0,  32'hFF0000FF},
        {64'hE4E4E4E4_001F_F800, 4'd1,  32'h0000FFFF},
        {64'hE4E4E4E4_001F_F800, 4'd2,  32'hAA0055FF},
        {64'hE4E4E4E4_001F_F800, 4'd3,  32'h5500AAFF},
        {64'hE4E4E4E4_001F_F800, 4'd7,  32'h5500AAFF},
        {64'hE4E4E4E4_001F_F800, 4'd13, 32'h0000FFFF},
        // three-colour layout, endpoints swapped (R4 R5)
        {64'hE4E4E4E4_F800_001F, 4'd0,  32'h0000FFFF},
        {64'hE4E4E4E4_F800_001F, 4'd2,  32'h7F007FFF},
        {64'hE4E4E4E4_F800_001F, 4'd3,  32'h00000000},
        {64'hE4E4E4E4_F800_001F, 4'd5,  32'hFF0000FF},
        // equal endpoints fall into three-colour layout (R4)
        {64'hFFFF0000_07E0_07E0, 4'd4,  32'h00FF00FF},
        {64'hFFFF0000_07E0_07E0, 4'd9,  32'h00000000},
        // bit replication and truncating thirds, selectors 3,2,1,0 (R2 R3)
        {64'h1B1B1B1B_0000_8401, 4'd0,  32'h2C2B02FF},
        {64'h1B1B1B1B_0000_8401, 4'd1,  32'h585605FF},
        {64'h1B1B1B1B_0000_8401, 4'd2,  32'h000000FF},
        {64'h1B1B1B1B_0000_8401, 4'd3,  32'h848208FF},
        // only texel 15 selects entry 3 (R6)
        {64'hC0000000_001F_F800, 4'd15, 32'h5500AAFF},
        {64'hC0000000_001F_F800, 4'd14, 32'hFF0000FF}
    };

    localparam logic [RGBA_W-1:0] RB_PAL [4] = '{
        32'hFF0000FF, 32'h0000FFFF, 32'hAA0055FF, 32'h5500AAFF
    };
    localparam logic [BLOCK_W-1:0] RB_BLOCK = 64'hE4E4E4E4_001F_F800;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_whole = 1'b0;
    logic [IDX_W-1:0]   req_index = '0;
    logic [BLOCK_W-1:0] req_block = '0;
    logic               out_valid;
    logic [IDX_W-1:0]   out_index;
    logic [RGBA_W-1:0]  out_rgba;
    logic               busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    texblk_decoder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_whole (req_whole),
        .req_index (req_index),
        .req_block (req_block),
        .out_valid (out_valid),
        .out_index (out_index),
        .out_rgba  (out_rgba),
        .busy      (busy)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic whole, input logic [IDX_W-1:0] idx,
                         input logic [BLOCK_W-1:0] blk);
        req_valid = v;
        req_whole = whole;
        req_index = idx;
        req_block = blk;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset holds outputs low even with a request present
        drive(1'b1, 1'b1, 4'd3, RB_BLOCK);
        repeat (3) @(negedge clk);
        check("R10 out_valid in reset", 64'(out_valid), 64'd0);
        check("R10 busy in reset", 64'(busy), 64'd0);
        drive(1'b0, 1'b0, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", 64'(out_valid), 64'd0);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [BLOCK_W-1:0] blk;
            logic [IDX_W-1:0]   idx;
            logic [RGBA_W-1:0]  exp;
            {blk, idx, exp} = VECS[i];
            drive(1'b1, 1'b0, idx, blk);
            @(negedge clk);
            drive(1'b0, 1'b0, '0, '0);
            check($sformatf("R7 vector %0d out_valid", i), 64'(out_valid), 64'd1);
            check($sformatf("R7 vector %0d out_index", i), 64'(out_index), 64'(idx));
            check($sformatf("R1 R2 R3 R4 R5 R6 vector %0d rgba", i), 64'(out_rgba), 64'(exp));
        end
        @(negedge clk);
        check("R10 idle after single", 64'(out_valid), 64'd0);

        // R8/R9: whole block, with competing requests mid-sequence
        drive(1'b1, 1'b1, 4'd9, RB_BLOCK);
        for (int k = 0; k < TEXELS; k++) begin
            @(negedge clk);
            if (k == 5) drive(1'b1, 1'b0, 4'd2, 64'hE4E4E4E4_F800_001F);
            else if (k == 9) drive(1'b1, 1'b1, 4'd0, 64'h1B1B1B1B_0000_8401);
            else drive(1'b0, 1'b0, '0, '0);
            check($sformatf("R8 stream %0d valid", k), 64'(out_valid), 64'd1);
            check($sformatf("R8 stream %0d index", k), 64'(out_index), 64'(k));
            check($sformatf("R8 R9 stream %0d rgba", k), 64'(out_rgba), 64'(RB_PAL[k % 4]));
            check($sformatf("R9 stream %0d busy", k), 64'(busy), (k < TEXELS-1) ? 64'd1 : 64'd0);
        end
        @(negedge clk);
        check("R10 idle after stream", 64'(out_valid), 64'd0);

        // R9: request while texel 15 shows is taken on the next edge
        drive(1'b1, 1'b1, 4'd0, 64'h1B1B1B1B_0000_8401);
        repeat (TEXELS) @(negedge clk);
        drive(1'b1, 1'b0, 4'd2, RB_BLOCK);
        check("R9 last texel index", 64'(out_index), 64'd15);
        check("R9 last texel busy", 64'(busy), 64'd0);
        check("R6 last texel rgba", 64'(out_rgba), 64'h848208FF);
        @(negedge clk);
        drive(1'b0, 1'b0, '0, '0);
        check("R9 follow-on accepted", 64'(out_valid), 64'd1);
        check("R9 follow-on index", 64'(out_index), 64'd2);
        check("R9 follow-on rgba", 64'(out_rgba), 64'hAA0055FF);

        // R10: reset in the middle of a sequence
        drive(1'b1, 1'b1, 4'd0, RB_BLOCK);
        repeat (4) @(negedge clk);
        drive(1'b0, 1'b0, '0, '0);
        rst_n = 1'b0;
        #1;
        check("R10 mid-stream reset valid", 64'(out_valid), 64'd0);
        check("R10 mid-stream reset busy", 64'(busy), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 no resume after reset", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule